// File: doc/BRIEF.md
# Receive Character FIFO with Interrupt Logic

This block sits on the receive side of a memory-mapped serial port, after the bit-level deserializer. Every character the deserializer hands over is stored in a 16-entry first-in first-out buffer, along with three error tags: framing, parity and break. Software reads the buffer through a small register strobe interface. Each read of the data register removes one entry.

Four status conditions are tracked: the buffer is not empty, its fill has reached a programmable level, it has held data with no new arrival for a programmable number of character times, and a character was lost because the buffer was full. Each condition has its own mask bit. The single interrupt output is asserted whenever an unmasked condition is active. The lost-character condition is sticky. Only a self-clearing flush bit in the control register removes it, and that bit also empties the buffer and restarts the idle timer.

One character time is counted as `frame_bits` pulses of the `baud_tick` input, which strobes once per bit period.

Top module: `rx_fifo_irq`

## Requirements
- R1: A read at address 0 of a non-empty buffer returns the oldest entry and removes it. The returned word holds the character in bits [7:0], framing error in bit 8, parity error in bit 9, break in bit 10 and a valid flag (1) in bit 11, with bits [15:12] zero. Entries come out in arrival order.
- R2: A read at address 0 while the buffer is empty returns 0 and changes no state.
- R3: The buffer holds 16 entries. A character that arrives while the buffer is full, with no read in the same cycle, is discarded and sets the overrun status (interrupt register bit 0). The stored entries are left intact.
- R4: A character that arrives in the same cycle as a read of a full buffer is accepted, and overrun is not set.
- R5: Overrun stays set through any number of reads until a flush occurs.
- R6: Writing 1 to bit 0 of the control register (address 1) raises a flush flag, which reads back in control bit 0 for exactly one cycle. The clock edge that ends that cycle empties the buffer and clears overrun. A character presented in that cycle is discarded.
- R7: The threshold status (interrupt register bit 1) is 1 while the fill is at or above control field [12:8]. After reset that field is 8.
- R8: The timeout status (interrupt register bit 2) sets once the buffer has been non-empty and received no new character for N character times, where N is control field [7:4] and one character time is `frame_bits` baud ticks. A new arrival or an emptied buffer restarts the count and clears the status. N = 0 disables it. After reset N is 1.
- R9: The not-empty status (interrupt register bit 3) is 1 exactly when the buffer holds at least one entry.
- R10: The interrupt register (address 2) returns the status in bits [3:0] and the mask in bits [11:8]. Writes load the mask from bits [11:8]. The `irq` output is 1 exactly when some status bit and its mask bit are both 1. Masks reset to 0.
- R11: After reset the buffer is empty, all status bits are 0, and the control register reads 0x0810.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | One-cycle strobe: a received character is presented |
| rx_char | input | 8 | Received character |
| rx_brk | input | 1 | Break detected for this character |
| rx_par_err | input | 1 | Parity error for this character |
| rx_frm_err | input | 1 | Framing error for this character |
| baud_tick | input | 1 | One pulse per bit period |
| frame_bits | input | 4 | Bit periods per character frame |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops at address 0) |
| reg_addr | input | 2 | Register address: 0 data, 1 control, 2 interrupt |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the addressed register (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
A character arrival and a software read can land on the same edge. When that happens while the buffer is full, the result decides whether the new character is kept or counted as an overrun. The bench fills the buffer to 16 entries, then raises `rx_valid` and a data read in one cycle. It then checks that the overrun bit stays clear and that draining returns the 15 older entries followed by the new one. A second collision, an arrival in the single cycle in which a flush takes effect, is provoked and judged by checking that the buffer reads as empty afterwards.

// File: rtl/rx_fifo_irq.sv
module rx_fifo_irq #(
  parameter int DEPTH   = 16,
  parameter int TMO_W   = 4,
  parameter int FRM_W   = 4,
  parameter int THR_RST = DEPTH / 2,
  parameter int TMO_RST = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic [7:0]       rx_char,
  input  logic             rx_brk,
  input  logic             rx_par_err,
  input  logic             rx_frm_err,
  input  logic             baud_tick,
  input  logic [FRM_W-1:0] frame_bits,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [1:0]       reg_addr,
  input  logic [15:0]      reg_wdata,
  output logic [15:0]      reg_rdata,
  output logic             irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_CTRL = 2'd1;
  localparam logic [1:0] A_IRQ  = 2'd2;
  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);
  localparam logic [TMO_W:0] ONE_T = 1;
  localparam logic [FRM_W:0] ONE_F = 1;

  logic [10:0]      mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [CW-1:0]    fill;
  logic [CW-1:0]    thr;
  logic [TMO_W-1:0] tmo_lim;
  logic [3:0]       mask;
  logic             rst_pend, ovr_q, tmo_q;
  logic [FRM_W-1:0] bit_cnt;
  logic [TMO_W-1:0] chr_cnt;

  wire empty = (fill == '0);
  wire full  = (fill == FULL_LVL);
  wire pop   = reg_rd && reg_addr == A_DATA && !empty && !rst_pend;
  wire push  = rx_valid && !rst_pend && (!full || pop);
  wire drop  = rx_valid && !rst_pend && full && !pop;
  wire wr_ctl = reg_wr && reg_addr == A_CTRL;
  wire wr_irq = reg_wr && reg_addr == A_IRQ;
  wire going_empty = pop && !push && fill == CW'(1);
  wire frame_end = ({1'b0, bit_cnt} + ONE_F) >= {1'b0, frame_bits};

  wire [3:0] status = {!empty, tmo_q, fill >= thr, ovr_q};
  assign irq = |(status & mask);

  wire unused_wdata = ^{reg_wdata[15:13], reg_wdata[3:1]};

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= {rx_brk, rx_par_err, rx_frm_err, rx_char};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      fill <= '0;
      ovr_q <= 1'b0;
    end else if (rst_pend) begin
      wptr <= '0;
      rptr <= '0;
      fill <= '0;
      ovr_q <= 1'b0;
    end else begin
      if (push) wptr <= (wptr == LAST_PTR) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == LAST_PTR) ? '0 : rptr + 1'b1;
      if (push && !pop)      fill <= fill + 1'b1;
      else if (pop && !push) fill <= fill - 1'b1;
      if (drop) ovr_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr <= CW'(THR_RST);
      tmo_lim <= TMO_W'(TMO_RST);
      mask <= '0;
      rst_pend <= 1'b0;
    end else begin
      rst_pend <= wr_ctl && reg_wdata[0];
      if (wr_ctl) begin
        thr <= reg_wdata[8 +: CW];
        tmo_lim <= reg_wdata[4 +: TMO_W];
      end
      if (wr_irq) mask <= reg_wdata[11:8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      chr_cnt <= '0;
      tmo_q <= 1'b0;
    end else if (rst_pend || push || empty || going_empty) begin
      bit_cnt <= '0;
      chr_cnt <= '0;
      tmo_q <= 1'b0;
    end else if (baud_tick) begin
      if (frame_end) begin
        bit_cnt <= '0;
        if (tmo_lim != '0 && !tmo_q) begin
          chr_cnt <= chr_cnt + 1'b1;
          if (({1'b0, chr_cnt} + ONE_T) >= {1'b0, tmo_lim}) tmo_q <= 1'b1;
        end
      end else begin
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_DATA: if (!empty) reg_rdata = {4'b0, 1'b1, mem[rptr]};
      A_CTRL: begin
        reg_rdata[8 +: CW]    = thr;
        reg_rdata[4 +: TMO_W] = tmo_lim;
        reg_rdata[0]          = rst_pend;
      end
      A_IRQ:  reg_rdata = {4'b0, mask, 4'b0, status};
      default: reg_rdata = '0;
    endcase
  end

  assert_fill_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FULL_LVL);
  assert_drop_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> (ovr_q && fill == FULL_LVL));
  assert_ovr_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !rst_pend) |=> ovr_q);
  assert_flush_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pend |=> (fill == '0 && !ovr_q));
  assert_empty_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_DATA && empty && !rx_valid) |=> empty);
  assert_tmo_needs_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_q |-> !empty);
  assert_mask_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == 4'b0) |-> !irq);
endmodule

// File: tb/rx_fifo_irq_tb.sv
module rx_fifo_irq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 1'b0, rx_brk = 1'b0, rx_par_err = 1'b0, rx_frm_err = 1'b0;
  logic [7:0] rx_char = '0;
  logic baud_tick = 1'b0;
  logic [3:0] frame_bits = 4'd10;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic irq;

  int nchk = 0;
  int nfail = 0;
  logic [15:0] expq [$];

  always #10 clk = ~clk;

  rx_fifo_irq u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_char(rx_char),
    .rx_brk(rx_brk), .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err),
    .baud_tick(baud_tick), .frame_bits(frame_bits), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string req);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: compares every popped entry with the scoreboard queue (R1)
  always @(negedge clk) begin
    #2;
    if (rst_n && reg_rd && reg_addr == 2'd0 && reg_rdata[11]) begin
      if (expq.size() == 0) check(reg_rdata, 16'h0000, "R1 unexpected entry");
      else check(reg_rdata, expq.pop_front(), "R1 entry order/content");
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1 reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a; #3 d = reg_rdata;
    @(posedge clk); #1 reg_rd = 1'b0;
  endtask

  task automatic send(input logic [7:0] c, input logic b, input logic p, input logic f);
    @(negedge clk); rx_valid = 1'b1; rx_char = c; rx_brk = b; rx_par_err = p; rx_frm_err = f;
    if (expq.size() < 16) expq.push_back({4'b0, 1'b1, b, p, f, c});
    @(posedge clk); #1 rx_valid = 1'b0;
  endtask

  task automatic pop_n(input int n);
    logic [15:0] d;
    for (int i = 0; i < n; i++) rd(2'd0, d);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); baud_tick = 1'b1;
      @(posedge clk); #1 baud_tick = 1'b0;
    end
  endtask

  task automatic expect_reg(input logic [1:0] a, input logic [15:0] e, input string req);
    logic [15:0] d;
    rd(a, d);
    check(d, e, req);
  endtask

  function automatic logic [15:0] ctl(input int t, input int m, input bit f);
    return 16'((t << 8) | (m << 4) | int'(f));
  endfunction

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R11 reset state
    expect_reg(2'd1, 16'h0810, "R11 ctrl reset");
    expect_reg(2'd2, 16'h0000, "R11 irq reg reset");
    check({15'b0, irq}, 16'h0, "R11 irq pin reset");
    // R2 empty read
    expect_reg(2'd0, 16'h0000, "R2 empty read");

    // R1 flags and order, R9 not-empty
    send(8'hA5, 1, 0, 0);
    send(8'h3C, 0, 1, 0);
    send(8'h7E, 0, 0, 1);
    send(8'h01, 0, 0, 0);
    expect_reg(2'd2, 16'h0008, "R9 not empty set");
    pop_n(4);
    expect_reg(2'd2, 16'h0000, "R9 not empty clear");
    expect_reg(2'd0, 16'h0000, "R2 empty read after drain");
    send(8'h55, 0, 0, 0);
    pop_n(1);

    // R7 threshold
    for (int i = 0; i < 7; i++) send(8'(8'h10 + i), 0, 0, 0);
    expect_reg(2'd2, 16'h0008, "R7 below threshold 7");
    send(8'h17, 0, 0, 0);
    expect_reg(2'd2, 16'h000A, "R7 at threshold 8");
    wr(2'd1, ctl(3, 1, 0));
    pop_n(5);
    expect_reg(2'd2, 16'h000A, "R7 fill 3 at threshold 3");
    pop_n(1);
    expect_reg(2'd2, 16'h0008, "R7 fill 2 below threshold 3");
    pop_n(2);
    wr(2'd1, ctl(8, 1, 0));

    // R3 overrun on full, R5 sticky, R6 flush
    for (int i = 0; i < 16; i++) send(8'(8'h40 + i), i[0], 0, 0);
    expect_reg(2'd2, 16'h000A, "R3 full no overrun");
    send(8'hFF, 0, 1, 1);
    expect_reg(2'd2, 16'h000B, "R3 overrun set");
    pop_n(16);
    expect_reg(2'd2, 16'h0001, "R5 overrun sticky after drain");
    expect_reg(2'd0, 16'h0000, "R3 dropped char absent");
    wr(2'd1, ctl(8, 1, 1));
    expect_reg(2'd1, 16'h0811, "R6 flush bit visible");
    expect_reg(2'd2, 16'h0000, "R5 overrun cleared by flush");
    expect_reg(2'd1, 16'h0810, "R6 flush bit self-cleared");

    // R6 flush empties and discards same-cycle arrival
    send(8'h61, 0, 0, 0);
    send(8'h62, 0, 0, 0);
    wr(2'd1, ctl(8, 1, 1));
    send(8'h63, 0, 0, 0);
    expq.delete();
    expect_reg(2'd2, 16'h0000, "R6 flushed and arrival discarded");

    // R4 push with pop on full
    for (int i = 0; i < 16; i++) send(8'(8'h80 + i), 0, 0, 0);
    @(negedge clk);
    rx_valid = 1'b1; rx_char = 8'hEE; rx_brk = 0; rx_par_err = 0; rx_frm_err = 0;
    reg_rd = 1'b1; reg_addr = 2'd0;
    expq.push_back(16'h08EE);
    @(posedge clk); #1 rx_valid = 1'b0; reg_rd = 1'b0;
    expect_reg(2'd2, 16'h000A, "R4 no overrun on push with pop");
    pop_n(16);
    expect_reg(2'd2, 16'h0000, "R4 drained");

    // R8 timeout, R10 masking
    wr(2'd1, ctl(8, 2, 0));
    send(8'h11, 0, 0, 0);
    ticks(19);
    expect_reg(2'd2, 16'h0008, "R8 before 2 char times");
    ticks(1);
    expect_reg(2'd2, 16'h000C, "R8 timeout after 20 ticks");
    check({15'b0, irq}, 16'h0, "R10 unmasked timeout quiet");
    wr(2'd2, 16'h0400);
    check({15'b0, irq}, 16'h1, "R10 masked timeout irq");
    send(8'h22, 0, 0, 0);
    expect_reg(2'd2, 16'h0408, "R8 arrival restarts timeout");
    check({15'b0, irq}, 16'h0, "R10 irq drops with timeout");
    ticks(20);
    expect_reg(2'd2, 16'h040C, "R8 timeout again");
    pop_n(2);
    expect_reg(2'd2, 16'h0400, "R8 empty clears timeout");
    wr(2'd1, ctl(8, 0, 0));
    send(8'h33, 0, 0, 0);
    ticks(40);
    expect_reg(2'd2, 16'h0408, "R8 zero disables timeout");
    pop_n(1);

    // R10 not-empty mask
    wr(2'd2, 16'h0800);
    check({15'b0, irq}, 16'h0, "R10 empty quiet");
    send(8'h44, 0, 0, 0);
    check({15'b0, irq}, 16'h1, "R10 not-empty irq");
    pop_n(1);
    check({15'b0, irq}, 16'h0, "R10 irq clears on drain");
    check(16'(expq.size()), 16'h0, "R1 all expected entries seen");

    repeat (2) @(posedge clk);
    summary();
  end
endmodule